// File: doc/BRIEF.md
# Compare-Match Timer Core

The block keeps an up-counter that advances by one on each count strobe from an upstream conditioning stage, for example a prescaler or an edge filter. When a strobe arrives while the count equals the programmed compare value, a compare event occurs. The event sets a sticky match flag and produces a one-cycle trigger pulse. The flag drives an interrupt line and a DMA request line, each gated by its own enable bit. After the event the counter either returns to zero, giving a period of compare+1 strobes, or keeps counting and wraps only at overflow.

Software reaches the block through a synchronous register port with three registers. The control/status register holds the enable and mode bits and the match flag, which is cleared by writing 1 to it. The compare register holds the match value. The counter register is read as a snapshot: a write of any value to it captures the live count, and later reads return the captured value.

Top module: `cmp_timer`

## Requirements
- R1: While enabled (control bit 0 = 1), each clock cycle with `tick_i` high adds one to the counter. Cycles without a strobe, and every strobe while disabled, leave the counter unchanged.
- R2: A compare event occurs when a strobe arrives while the counter equals the compare register (address 1). With free-run (control bit 2) clear, the counter returns to 0 at that strobe, so the period is compare+1 strobes.
- R3: With free-run set, the counter moves past the compare value and wraps to 0 only on overflow at 2^CNT_W. An event then fires once per wrap, on the strobe that moves the count from compare to compare+1.
- R4: The match flag (control bit 7) sets on the clock edge of a compare event. Writing 1 to bit 7 clears it and writing 0 leaves it unchanged. When an event and a clearing write fall on the same edge, the flag stays set.
- R5: `irq_o` is high exactly while the match flag and the interrupt enable (control bit 6) are both 1.
- R6: `trig_o` is high for one cycle after each compare event, in the same cycle in which the flag first reads as set.
- R7: `dma_req_o` is high exactly while the match flag and the DMA enable (control bit 8) are both 1.
- R8: Clearing the enable bit forces the counter to 0. After the enable bit is set again, counting resumes from 0.
- R9: A write of any data to address 2 captures the current count. Reads of address 2 return the captured value, zero-extended, until the next capture.
- R10: The control register reads as {bit8 DMA enable, bit7 flag, bit6 interrupt enable, bit2 free-run, bit1 mode, bit0 enable} with all other bits 0. Bit 1 is stored and read back but has no effect on counting. Address 3 reads 0. After reset every register and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe from the conditioning stage |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 counter snapshot |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | One-cycle trigger pulse per compare event |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench builds the block with CNT_W = 8 and DATA_W = 16. With these widths a full wrap of the free-running counter takes 256 strobes, so the bench can check the once-per-wrap event and the overflow to zero directly. The narrow counter also leaves the upper bits of the snapshot register above the count width, where the bench checks the zero extension.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_SNAP = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_MODE = 1;
  localparam int unsigned BIT_FREE = 2;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_DMA  = 8;
  localparam int unsigned CTRL_MSB = BIT_DMA;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             free_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             match;

  assign match = (cnt_q == cmp_i);
  assign evt_o = en_i & tick_i & match;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (match && !free_i)     cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !match) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && match && !free_i) |=> (cnt_q == '0));
  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && match && free_i) |=> (cnt_q == CNT_W'($past(cmp_i) + 1'b1)));
  p_off_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_timer_flag.sv
module cmp_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic dma_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic trig_o,
  output logic dma_req_o
);
  logic flag_q, trig_q;

  // hardware set has priority over the software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      flag_q <= evt_i | (flag_q & ~clr_i);
      trig_q <= evt_i;
    end
  end

  assign flag_o    = flag_q;
  assign trig_o    = trig_q;
  assign irq_o     = flag_q & ie_i;
  assign dma_req_o = flag_q & dma_en_i;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_q);
  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_q);
  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  p_trig_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> flag_q);
  p_trig_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> !trig_q);
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic              en_o,
  output logic              free_o,
  output logic              ie_o,
  output logic              dma_en_o,
  output logic              flag_clr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic             en_q, mode_q, free_q, ie_q, dma_q;
  logic [CNT_W-1:0] cmp_q, snap_q;
  logic             wr_ctrl, wr_cmp, wr_snap;
  logic             unused_wdata;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_cmp  = wr_en_i && (addr_i == ADDR_CMP);
  assign wr_snap = wr_en_i && (addr_i == ADDR_SNAP);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      free_q <= 1'b0;
      ie_q   <= 1'b0;
      dma_q  <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[BIT_EN];
      mode_q <= wdata_i[BIT_MODE];
      free_q <= wdata_i[BIT_FREE];
      ie_q   <= wdata_i[BIT_IE];
      dma_q  <= wdata_i[BIT_DMA];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (wr_snap) snap_q <= cnt_i;
  end

  assign en_o       = en_q;
  assign free_o     = free_q;
  assign ie_o       = ie_q;
  assign dma_en_o   = dma_q;
  assign cmp_o      = cmp_q;
  assign flag_clr_o = wr_ctrl & wdata_i[BIT_FLAG];

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL: begin
        rdata_o[BIT_EN]   = en_q;
        rdata_o[BIT_MODE] = mode_q;
        rdata_o[BIT_FREE] = free_q;
        rdata_o[BIT_IE]   = ie_q;
        rdata_o[BIT_FLAG] = flag_i;
        rdata_o[BIT_DMA]  = dma_q;
      end
      ADDR_CMP:  rdata_o = DATA_W'(cmp_q);
      ADDR_SNAP: rdata_o = DATA_W'(snap_q);
      default:   rdata_o = '0;
    endcase
  end

  p_snap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_snap |=> (snap_q == $past(cnt_i)));
  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_snap |=> $stable(snap_q));
  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> ($stable(en_q) && $stable(free_q) && $stable(ie_q) && $stable(dma_q)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              trig_o,
  output logic              dma_req_o
);
  logic             en, free, ie, dma_en, flag_clr, flag, evt;
  logic [CNT_W-1:0] cmp, cnt;

  cmp_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .flag_i(flag), .en_o(en), .free_o(free),
    .ie_o(ie), .dma_en_o(dma_en), .flag_clr_o(flag_clr), .cmp_o(cmp),
    .rdata_o(rdata_o)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .free_i(free), .tick_i(tick_i),
    .cmp_i(cmp), .cnt_o(cnt), .evt_o(evt)
  );

  cmp_timer_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .clr_i(flag_clr), .ie_i(ie),
    .dma_en_i(dma_en), .flag_o(flag), .irq_o(irq_o), .trig_o(trig_o),
    .dma_req_o(dma_req_o)
  );

  p_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && ie));
  p_dma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (flag && dma_en));
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq, trig, dma;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .trig_o(trig), .dma_req_o(dma)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic snap(output logic [DATA_W-1:0] d);
    wr(2'd2, '0); rd(2'd2, d);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic test_reset();
    logic [DATA_W-1:0] d;
    rd(2'd0, d); chk("R10 ctrl reset", d, 0);
    rd(2'd1, d); chk("R10 cmp reset", d, 0);
    rd(2'd2, d); chk("R10 snap reset", d, 0);
    rd(2'd3, d); chk("R10 addr3 zero", d, 0);
    chk("R10 outputs reset", {irq, trig, dma}, 0);
  endtask

  task automatic test_period();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd4); wr(2'd0, 16'h0041);
    ticks(4);
    chk("R2 no flag before event", irq, 0);
    snap(d); chk("R1 count after 4 strobes", d, 4);
    ticks(1);
    chk("R6 trig pulse", trig, 1);
    chk("R5 irq on flag", irq, 1);
    @(negedge clk); chk("R6 trig one cycle", trig, 0);
    snap(d); chk("R2 reload to zero", d, 0);
  endtask

  task automatic test_w1c();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0041); rd(2'd0, d); chk("R4 write 0 keeps flag", d, 16'h00C1);
    wr(2'd0, 16'h00C1); rd(2'd0, d); chk("R4 write 1 clears flag", d, 16'h0041);
    chk("R5 irq drops", irq, 0);
  endtask

  task automatic test_gating();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd1); wr(2'd0, 16'h0101);
    ticks(2);
    chk("R5 irq masked", irq, 0);
    chk("R7 dma while flag", dma, 1);
    rd(2'd0, d); chk("R10 ctrl readback", d, 16'h0181);
    wr(2'd0, 16'h0181); chk("R7 dma drops", dma, 0);
  endtask

  task automatic test_free();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd3); wr(2'd0, 16'h0005);
    ticks(4);
    rd(2'd0, d); chk("R3 first event", d[7], 1);
    snap(d); chk("R3 passes compare", d, 4);
    wr(2'd0, 16'h0085);
    ticks(255);
    rd(2'd0, d); chk("R3 no event across wrap", d[7], 0);
    snap(d); chk("R3 wrapped count", d, 3);
    ticks(1);
    rd(2'd0, d); chk("R3 event once per wrap", d[7], 1);
    snap(d); chk("R9 snapshot zero-extended", d, 4);
  endtask

  task automatic test_enable();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd200); wr(2'd0, 16'h0001);
    ticks(10);
    snap(d); chk("R1 count 10", d, 10);
    ticks(0);
    repeat (3) @(negedge clk);
    snap(d); chk("R1 hold without strobe", d, 10);
    wr(2'd0, 16'h0000);
    snap(d); chk("R8 disable clears", d, 0);
    ticks(5);
    snap(d); chk("R1 no count when disabled", d, 0);
    wr(2'd0, 16'h0001); ticks(2);
    snap(d); chk("R8 restart from zero", d, 2);
    wr(2'd1, 16'd77);
    rd(2'd2, d); chk("R9 snapshot held", d, 2);
  endtask

  task automatic test_set_wins();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd0); wr(2'd0, 16'h0001);
    ticks(1);
    rd(2'd0, d); chk("R4 flag set", d, 16'h0081);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 16'h0081;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, d); chk("R4 set wins over clear", d, 16'h0081);
    wr(2'd0, 16'h0081); rd(2'd0, d); chk("R4 later clear", d, 16'h0001);
  endtask

  task automatic test_mode();
    logic [DATA_W-1:0] d;
    wr(2'd0, 16'h0002); rd(2'd0, d); chk("R10 mode bit stored", d, 16'h0002);
    wr(2'd0, 16'hFF38); rd(2'd0, d); chk("R10 reserved bits read 0", d, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_period();
    test_w1c();
    test_gating();
    test_free();
    test_enable();
    test_set_wins();
    test_mode();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule